// File: doc/BRIEF.md
# Page Write Buffer with Wrap Addressing

This block sits between a serial memory slave engine and the logic that commits data into a nonvolatile array. The array is organised as 512 pages of 64 bytes, so a 15-bit byte address splits into a 9-bit page number (upper bits) and a 6-bit offset within the page (lower bits). The block keeps one address counter. It gathers the data bytes of one page write into a 64-entry buffer, marking each filled position with a valid flag. It presents the buffered page image, the page number and the flags to the commit logic.

The single counter follows two rollover rules. An accepted write byte advances only the 6-bit offset, so the offset wraps from 63 to 0 inside the same page. A read-increment request advances the full 15-bit address, wrapping from 7FFFh to 0000h. After any access the counter holds the address after the last byte read or written, and a current-address read uses that value. The counter value after reset carries no meaning. The slave engine must load an address before the first access.

Write bytes arrive on a valid/ready stream. A byte transfers on a clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, the producer holds `wr_valid` and `wr_data` steady. The block drops `wr_ready` while the commit logic is programming the page, and also in any cycle that carries a load or a flag clear. The load, read-increment, commit and abort pins are plain single-cycle controls.

Top module: `page_wr_buf`

## Requirements
- R1: After reset every flag in `page_valid` is 0, and `wr_ready` is 1 while `commit_active`, `load_valid`, `commit_done` and `abort` are all low.
- R2: A cycle with `load_valid` high sets `cur_addr` to `load_addr` on the next edge and clears all flags in `page_valid`.
- R3: An accepted write byte is stored at offset `cur_addr[5:0]`, and that offset's bit in `page_valid` is set. Byte k of the image is `page_data[8k+7:8k]`, and `page_addr` always equals `cur_addr[14:6]`.
- R4: An accepted write adds one to `cur_addr[5:0]` modulo 64 and leaves `cur_addr[14:6]` unchanged, so offset 63 is followed by offset 0 of the same page.
- R5: A page write of 64 bytes that starts at any offset sets all 64 flags and leaves the counter at the starting offset. A later byte at an already filled offset replaces the earlier byte, and its flag stays set.
- R6: A `rd_inc` pulse that is not overridden adds one to the full 15-bit `cur_addr`, and 7FFFh is followed by 0000h.
- R7: `wr_ready` is low whenever `commit_active`, `load_valid`, `commit_done` or `abort` is high. No write is taken in such a cycle: buffer, flags and counter (apart from a load) stay as they were.
- R8: `commit_done` or `abort` clears every flag in `page_valid` on the next edge. The clear itself leaves `cur_addr` unchanged.
- R9: Counter priority is load, then accepted write, then `rd_inc`. A `rd_inc` in the same cycle as a load or an accepted write is ignored.
- R10: With `wr_valid` low, the buffer, the flags and `cur_addr` are unaffected by `wr_data` and by `wr_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Load `load_addr` into the counter and clear flags |
| load_addr | input | 15 | Address to load |
| wr_valid | input | 1 | Write byte stream valid |
| wr_ready | output | 1 | Write byte stream ready |
| wr_data | input | 8 | Write byte |
| rd_inc | input | 1 | Read-increment request |
| commit_active | input | 1 | Commit logic is programming the page; stalls writes |
| commit_done | input | 1 | Commit finished; clears flags |
| abort | input | 1 | Page write abandoned; clears flags |
| cur_addr | output | 15 | Current address counter |
| page_addr | output | 9 | Page number of the buffered image |
| page_valid | output | 64 | Per-offset filled flags |
| page_data | output | 512 | Buffered page image, byte k at bits 8k+7..8k |

## Verification
Directed cases cover the three wrap points. A write at offset 63 separates page-local rollover from a carry into the page number. A read increment at 7FFFh separates full-space rollover from a page-local one. A 64-byte load from mid-page, followed by overwrites, shows whether the counter returns to its start offset and whether later bytes replace earlier ones. Seeded random mixes of loads, writes, stalled writes, read increments, clears, and writes that collide with a read increment in one cycle then test the priority order and back-pressure against a bench model of the counter, flags and image.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Counter update selected for the coming edge
  typedef enum logic [1:0] {
    CTR_HOLD      = 2'd0,
    CTR_LOAD      = 2'd1,
    CTR_STEP_PAGE = 2'd2,
    CTR_STEP_ALL  = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_valid,
  input  logic    wr_valid,
  input  logic    rd_inc,
  input  logic    commit_active,
  input  logic    commit_done,
  input  logic    abort,
  output logic    wr_ready,
  output logic    wr_take,
  output logic    flag_clr,
  output ctr_op_e ctr_op
);
  logic stall;

  assign flag_clr = commit_done | abort | load_valid;
  assign stall    = commit_active | load_valid | commit_done | abort;
  assign wr_ready = ~stall;
  assign wr_take  = wr_valid & ~stall;

  always_comb begin
    ctr_op = CTR_HOLD;
    if (load_valid)   ctr_op = CTR_LOAD;
    else if (wr_take) ctr_op = CTR_STEP_PAGE;
    else if (rd_inc)  ctr_op = CTR_STEP_ALL;
  end

  // R7
  stall_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_active | commit_done | abort) |-> (ctr_op != CTR_STEP_PAGE));
endmodule

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr
  import pwb_pkg::*;
#(
  parameter int PAGE_BITS = 9,
  parameter int OFS_BITS  = 6,
  localparam int ADDR_W   = PAGE_BITS + OFS_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctr_op_e           op,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0]    addr_q;
  logic [ADDR_W-1:0]    addr_d;
  logic [OFS_BITS-1:0]  ofs_next;
  logic [ADDR_W-1:0]    all_next;

  assign ofs_next = addr_q[OFS_BITS-1:0] + 1'b1;
  assign all_next = addr_q + 1'b1;

  always_comb begin
    unique case (op)
      CTR_LOAD:      addr_d = ld_addr;
      CTR_STEP_PAGE: addr_d = {addr_q[ADDR_W-1:OFS_BITS], ofs_next};
      CTR_STEP_ALL:  addr_d = all_next;
      default:       addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R2
  load_takes_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CTR_LOAD) |=> (addr == $past(ld_addr)));
  // R4
  page_step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CTR_STEP_PAGE) |=> (addr[ADDR_W-1:OFS_BITS] == $past(addr[ADDR_W-1:OFS_BITS])
      && addr[OFS_BITS-1:0] == OFS_BITS'($past(addr[OFS_BITS-1:0]) + 1)));
  // R6
  full_step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CTR_STEP_ALL) |=> (addr == ADDR_W'($past(addr) + 1)));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CTR_HOLD) |=> $stable(addr));
endmodule

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
  parameter int OFS_BITS = 6,
  parameter int DATA_W   = 8,
  localparam int DEPTH   = 1 << OFS_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [OFS_BITS-1:0]     idx,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    clr,
  output logic [DEPTH-1:0]        vld,
  output logic [DEPTH*DATA_W-1:0] image
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = we && (idx == OFS_BITS'(i));

    always_ff @(posedge clk) begin
      if (hit) mem_q[i] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   vld_q[i] <= 1'b0;
      else if (clr) vld_q[i] <= 1'b0;
      else if (hit) vld_q[i] <= 1'b1;
    end

    assign image[i*DATA_W +: DATA_W] = mem_q[i];
  end

  assign vld = vld_q;

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (vld_q[$past(idx)] && mem_q[$past(idx)] == $past(wdata)));
  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));
  // R10
  idle_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> $stable(vld_q));
endmodule

// File: rtl/page_wr_buf.sv
module page_wr_buf
  import pwb_pkg::*;
#(
  parameter int PAGE_BITS = 9,
  parameter int OFS_BITS  = 6,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = PAGE_BITS + OFS_BITS,
  localparam int DEPTH    = 1 << OFS_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_valid,
  input  logic [ADDR_W-1:0]       load_addr,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_inc,
  input  logic                    commit_active,
  input  logic                    commit_done,
  input  logic                    abort,
  output logic [ADDR_W-1:0]       cur_addr,
  output logic [PAGE_BITS-1:0]    page_addr,
  output logic [DEPTH-1:0]        page_valid,
  output logic [DEPTH*DATA_W-1:0] page_data
);
  ctr_op_e ctr_op;
  logic    wr_take;
  logic    flag_clr;

  pwb_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_valid    (load_valid),
    .wr_valid      (wr_valid),
    .rd_inc        (rd_inc),
    .commit_active (commit_active),
    .commit_done   (commit_done),
    .abort         (abort),
    .wr_ready      (wr_ready),
    .wr_take       (wr_take),
    .flag_clr      (flag_clr),
    .ctr_op        (ctr_op)
  );

  pwb_addr_ctr #(
    .PAGE_BITS (PAGE_BITS),
    .OFS_BITS  (OFS_BITS)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (ctr_op),
    .ld_addr (load_addr),
    .addr    (cur_addr)
  );

  pwb_page_store #(
    .OFS_BITS (OFS_BITS),
    .DATA_W   (DATA_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_take),
    .idx   (cur_addr[OFS_BITS-1:0]),
    .wdata (wr_data),
    .clr   (flag_clr),
    .vld   (page_valid),
    .image (page_data)
  );

  assign page_addr = cur_addr[ADDR_W-1:OFS_BITS];

  // R7
  stall_freezes_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_active && !load_valid && !commit_done && !abort) |=> $stable(page_valid));
  // R9
  write_beats_rdinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_inc) |=>
      (cur_addr[ADDR_W-1:OFS_BITS] == $past(cur_addr[ADDR_W-1:OFS_BITS])));
endmodule

// File: tb/page_wr_buf_tb.sv
module page_wr_buf_tb;
  localparam int AW = 15;
  localparam int NB = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_valid = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data = '0;
  logic          rd_inc = 1'b0;
  logic          commit_active = 1'b0;
  logic          commit_done = 1'b0;
  logic          abort = 1'b0;
  logic [AW-1:0] cur_addr;
  logic [8:0]    page_addr;
  logic [NB-1:0] page_valid;
  logic [NB*8-1:0] page_data;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] m_addr;
  logic [NB-1:0] m_vld;
  logic [7:0]    m_mem [NB];

  always #2.5 clk = ~clk;

  page_wr_buf u_dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_addr(load_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .rd_inc(rd_inc),
    .commit_active(commit_active), .commit_done(commit_done), .abort(abort),
    .cur_addr(cur_addr), .page_addr(page_addr), .page_valid(page_valid),
    .page_data(page_data)
  );

  function automatic logic [AW-1:0] wr_next(input logic [AW-1:0] a);
    return {a[14:6], 6'(a[5:0] + 6'd1)};
  endfunction

  function automatic logic [AW-1:0] rd_next(input logic [AW-1:0] a);
    return AW'(a + 1'b1);
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, 512'(cur_addr), 512'(m_addr));
    chk("R3 page_addr", 512'(page_addr), 512'(m_addr[14:6]));
    chk(req, 512'(page_valid), 512'(m_vld));
    for (int i = 0; i < NB; i++)
      if (m_vld[i] && page_data[i*8 +: 8] !== m_mem[i]) begin
        checks++; failures++;
        $display("FAIL %s byte %0d actual=%0h expected=%0h", req, i, page_data[i*8 +: 8], m_mem[i]);
      end
  endtask

  // One cycle of stimulus, model update, then a check after the edge
  task automatic step(input logic ld, input logic [AW-1:0] la, input logic wv,
                      input logic [7:0] wd, input logic ri, input logic ca,
                      input logic cd, input logic ab, input string req);
    logic rdy, take;
    @(negedge clk);
    load_valid = ld; load_addr = la; wr_valid = wv; wr_data = wd;
    rd_inc = ri; commit_active = ca; commit_done = cd; abort = ab;
    rdy = !(ca | ld | cd | ab);
    #1;
    chk("R7 wr_ready", 512'(wr_ready), 512'(rdy));
    take = wv && rdy;
    if (take) begin m_mem[m_addr[5:0]] = wd; end
    if (ld | cd | ab) m_vld = '0;
    else if (take) m_vld[m_addr[5:0]] = 1'b1;
    if (ld) m_addr = la;
    else if (take) m_addr = wr_next(m_addr);
    else if (ri) m_addr = rd_next(m_addr);
    @(negedge clk);
    load_valid = 0; wr_valid = 0; rd_inc = 0; commit_active = 0;
    commit_done = 0; abort = 0; wr_data = 8'hxx === 8'h00 ? 8'h00 : 8'h5A;
    check_state(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int op;
    void'($urandom(32'd7151));
    m_addr = '0; m_vld = '0;
    for (int i = 0; i < NB; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", 512'(page_valid), 512'(0));
    chk("R1 ready", 512'(wr_ready), 512'(1));

    // R2 load, R6 full-space wrap
    step(1, 15'h7FFF, 0, 0, 0, 0, 0, 0, "R2 load");
    m_addr = 15'h7FFF;
    step(0, 0, 0, 0, 1, 0, 0, 0, "R6 wrap 7FFF");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R6 step");
    // R4 page-local wrap at offset 63
    step(1, {9'd5, 6'd63}, 0, 0, 0, 0, 0, 0, "R2 load");
    step(0, 0, 1, 8'hA1, 0, 0, 0, 0, "R4 wrap 63");
    step(0, 0, 1, 8'hA2, 0, 0, 0, 0, "R3 write");
    // R5 64 bytes from mid-page, then overwrites
    step(1, {9'd300, 6'd32}, 0, 0, 0, 0, 0, 0, "R2 load");
    for (int k = 0; k < 64; k++) step(0, 0, 1, 8'(k + 16), 0, 0, 0, 0, "R5 fill");
    chk("R5 back at start", 512'(cur_addr[5:0]), 512'(32));
    chk("R5 all flags", 512'(page_valid), {448'd0, {64{1'b1}}});
    for (int k = 0; k < 3; k++) step(0, 0, 1, 8'(8'hE0 + k), 0, 0, 0, 0, "R5 overwrite");
    // R7 stalled write, R9 write vs read increment, R10 idle data
    step(0, 0, 1, 8'h77, 0, 1, 0, 0, "R7 stall");
    step(0, 0, 1, 8'h66, 1, 0, 0, 0, "R9 write wins");
    step(1, 15'h1234, 0, 0, 1, 0, 0, 0, "R9 load wins");
    step(0, 0, 0, 8'h99, 0, 0, 0, 0, "R10 idle");
    // R8 clears
    step(0, 0, 1, 8'h11, 0, 0, 0, 0, "R3 write");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R8 commit_done");
    step(0, 0, 1, 8'h22, 0, 0, 0, 0, "R3 write");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8 abort");

    // Seeded random mix
    for (int n = 0; n < 600; n++) begin
      op = int'($urandom_range(0, 9));
      case (op)
        0: step(1, 15'($urandom), 0, 0, 0, 0, 0, 0, "R2 rand load");
        1, 2, 3: step(0, 0, 1, 8'($urandom), 0, 0, 0, 0, "R4 rand write");
        4: step(0, 0, 1, 8'($urandom), 0, 1, 0, 0, "R7 rand stall");
        5: step(0, 0, 0, 0, 1, 0, 0, 0, "R6 rand rdinc");
        6: step(0, 0, 1, 8'($urandom), 1, 0, 0, 0, "R9 rand both");
        7: step(0, 0, 0, 0, 0, 0, $urandom_range(0, 9) == 0, 0, "R8 rand done");
        8: step(0, 0, 0, 8'($urandom), 0, 0, 0, $urandom_range(0, 9) == 0, "R10 rand idle");
        default: step(0, 0, 1, 8'($urandom), 0, 0, 0, 0, "R5 rand write");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule